// File: doc/BRIEF.md
# Serial Burst-Write Receiver with CRC Check

This block receives a debug burst write one serial bit per shift cycle. It first collects a 53-bit command, most significant bit first. The command holds a module flag, a 4-bit opcode, a 32-bit start address and a 16-bit word count. A write opcode arms the block for the data scan. The other commands are dropped without any effect.

In the data scan, zero bits are skipped until a single 1 bit marks the start of the payload. The payload words then arrive least significant bit first, and their size is set by the opcode. After each word is complete, the block raises a one-cycle write request that carries the current address, and the address then advances by the word size.

After the last word, a 32-bit CRC arrives least significant bit first. The block compares it with its own CRC-32 over the payload and returns one match bit on the serial output. A bus error reported against a request is captured in a sticky flag, together with the address of that request.

Top module: `burst_write_rx`

## Requirements
- R1: During and directly after reset, `tdo`, `wr_req`, `err_flag`, `err_addr`, `wr_addr`, `wr_data` and `wr_size` are all zero, and the block waits for a command.
- R2: A command is 53 serial bits, most significant first. Bit 52 is the module flag, bits 51..48 are the opcode, bits 47..16 are the start address and bits 15..0 are the word count. The bit counter restarts after every 53 bits.
- R3: A command is ignored when its flag is 1 or its opcode is not 1, 2 or 3. No request is made, `tdo` stays 0, and the next 53 bits are decoded as a new command.
- R4: After a write command is accepted, 0 bits are ignored. The first 1 bit starts the payload and is not part of the payload.
- R5: Opcode 1, 2 or 3 selects 8-, 16- or 32-bit words, which arrive least significant bit first. Each complete word gives a `wr_req` pulse of exactly one cycle. With it, `wr_data` carries the zero-extended word and `wr_size` carries 0, 1 or 2 (the opcode minus one).
- R6: The first request uses the start address. Each later request uses the previous address plus 1, 2 or 4 bytes, modulo 2^32.
- R7: A burst makes exactly as many requests as the word count. A count of 0 makes no request, and the CRC follows the start bit directly.
- R8: The expected CRC is the bit-reflected CRC-32 with polynomial 0xEDB88320. It starts at 0xFFFFFFFF, runs over the payload bits in the order they arrive, and is complemented at the end. The received CRC arrives least significant bit first.
- R9: After the last CRC bit, `tdo` shows 1 if the two CRCs match and 0 if they do not. It holds this value until the next shift cycle, after which the block waits for a command. At all other times `tdo` is 0.
- R10: A `bus_err` pulse sets `err_flag` and loads `err_addr` with the address of the most recent request. Both then hold until a new write command is accepted, which clears them. Ignored commands do not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sh_en | input | 1 | One serial bit is shifted in on this cycle |
| sh_bit | input | 1 | Serial input bit |
| tdo | output | 1 | Serial return bit carrying the CRC match result |
| wr_req | output | 1 | Write request pulse, one cycle per word |
| wr_addr | output | 32 | Byte address of the request |
| wr_data | output | 32 | Zero-extended write data |
| wr_size | output | 2 | Word size code: 0 = byte, 1 = half-word, 2 = word |
| bus_err | input | 1 | The bus reports an error for the most recent request |
| err_flag | output | 1 | Sticky bus error flag |
| err_addr | output | 32 | Address captured with the first error |

## Verification
The assertions assume that `bus_err` never arrives in the same cycle that a write command is accepted, and that shifts come no faster than one bit per cycle. Under that assumption, request pulses are always separated by at least seven cycles. The stimulus sends whole 53-bit commands so that the decoder stays aligned. It inserts idle cycles only between payload bits, and it pulses the error input only while the block is waiting for a command. Random bursts cover all three word sizes, counts up to six, address wrap-around, a random number of leading zero bits and randomly corrupted CRC bits.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
    typedef enum logic [2:0] {
        ST_CMD   = 3'd0,
        ST_WAIT  = 3'd1,
        ST_DATA  = 3'd2,
        ST_CRC   = 3'd3,
        ST_MATCH = 3'd4
    } bwr_state_e;

    localparam logic [3:0] OP_WR8  = 4'h1;
    localparam logic [3:0] OP_WR32 = 4'h3;

    function automatic logic is_write_op(input logic [3:0] op);
        return (op >= OP_WR8) && (op <= OP_WR32);
    endfunction
endpackage

// File: rtl/bwr_crc_serial.sv
module bwr_crc_serial #(
    parameter int          CRC_W = 32,
    parameter logic [31:0] POLY  = 32'hEDB88320
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q
);
    logic [CRC_W-1:0] crc_d;
    logic             fb;

    always_comb begin
        crc_d = crc_q;
        fb    = crc_q[0] ^ din;
        if (init) begin
            crc_d = '1;
        end else if (en) begin
            crc_d = {1'b0, crc_q[CRC_W-1:1]} ^ (fb ? POLY[CRC_W-1:0] : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    // R8: each burst starts from the all-ones seed
    assert_crc_seed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc_q == '1));
endmodule

// File: rtl/bwr_cmd_shift.sv
module bwr_cmd_shift #(
    parameter int LEN = 53
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           din,
    output logic           done,
    output logic [LEN-1:0] word
);
    localparam int CW = $clog2(LEN);

    typedef struct packed {
        logic [LEN-2:0] sr;
        logic [CW-1:0]  cnt;
    } cmd_t;

    cmd_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = en && (s_q.cnt == CW'(LEN - 1));
        word = {s_q.sr, din};
        if (en) begin
            s_d.sr  = {s_q.sr[LEN-3:0], din};
            s_d.cnt = done ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: bit counter never passes the command length
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(LEN - 1));
endmodule

// File: rtl/bwr_err_trap.sv
module bwr_err_trap #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              err,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              flag_q,
    output logic [ADDR_W-1:0] addr_q
);
    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] addr;
    } trap_t;

    trap_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (err && !s_q.flag) begin
            s_d.flag = 1'b1;
            s_d.addr = addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_q = s_q.flag;
    assign addr_q = s_q.addr;

    // R10: flag and captured address persist until cleared
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> (flag_q && $stable(addr_q)));
endmodule

// File: rtl/burst_write_rx.sv
module burst_write_rx #(
    parameter int          OP_W     = 4,
    parameter int          ADDR_W   = 32,
    parameter int          CNT_W    = 16,
    parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sh_en,
    input  logic              sh_bit,
    output logic              tdo,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic [1:0]        wr_size,
    input  logic              bus_err,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    import bwr_pkg::*;

    localparam int DATA_W  = 32;
    localparam int CRC_W   = 32;
    localparam int CMD_LEN = 1 + OP_W + ADDR_W + CNT_W;
    localparam int BC_W    = $clog2(DATA_W);

    typedef struct packed {
        bwr_state_e        st;
        logic [1:0]        size;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [BC_W-1:0]   bitc;
        logic [DATA_W-1:0] word;
        logic [CRC_W-1:0]  rxcrc;
        logic              match;
        logic              req;
        logic [ADDR_W-1:0] req_addr;
        logic [DATA_W-1:0] req_data;
        logic [1:0]        req_size;
    } rx_t;

    rx_t s_d, s_q;

    logic               cmd_en, cmd_done, accept;
    logic [CMD_LEN-1:0] cmd_word;
    logic               crc_init, crc_en;
    logic [CRC_W-1:0]   crc_q;
    logic [BC_W-1:0]    last_bit;
    logic [OP_W-1:0]    cmd_op;
    logic [CRC_W-1:0]   rx_full;

    assign cmd_en = sh_en && (s_q.st == ST_CMD);
    assign cmd_op = cmd_word[CMD_LEN-2 -: OP_W];

    bwr_cmd_shift #(.LEN(CMD_LEN)) u_cmd (
        .clk(clk), .rst_n(rst_n), .en(cmd_en), .din(sh_bit),
        .done(cmd_done), .word(cmd_word)
    );

    bwr_crc_serial #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
        .din(sh_bit), .crc_q(crc_q)
    );

    bwr_err_trap #(.ADDR_W(ADDR_W)) u_err (
        .clk(clk), .rst_n(rst_n), .clr(accept), .err(bus_err),
        .addr_in(s_q.req_addr), .flag_q(err_flag), .addr_q(err_addr)
    );

    always_comb begin
        case (s_q.size)
            2'd0:    last_bit = BC_W'(7);
            2'd1:    last_bit = BC_W'(15);
            default: last_bit = BC_W'(31);
        endcase
    end

    assign rx_full = {sh_bit, s_q.rxcrc[CRC_W-1:1]};

    always_comb begin
        s_d      = s_q;
        s_d.req  = 1'b0;
        accept   = 1'b0;
        crc_init = 1'b0;
        crc_en   = 1'b0;
        case (s_q.st)
            ST_CMD: begin
                if (cmd_done && !cmd_word[CMD_LEN-1] && is_write_op(4'(cmd_op))) begin
                    accept   = 1'b1;
                    crc_init = 1'b1;
                    s_d.st   = ST_WAIT;
                    s_d.size = 2'(cmd_op - 1'b1);
                    s_d.addr = cmd_word[CNT_W +: ADDR_W];
                    s_d.cnt  = cmd_word[CNT_W-1:0];
                end
            end
            ST_WAIT: begin
                if (sh_en && sh_bit) begin
                    s_d.bitc = '0;
                    s_d.word = '0;
                    s_d.st   = (s_q.cnt == '0) ? ST_CRC : ST_DATA;
                end
            end
            ST_DATA: begin
                if (sh_en) begin
                    crc_en   = 1'b1;
                    s_d.word = s_q.word | (DATA_W'(sh_bit) << s_q.bitc);
                    if (s_q.bitc == last_bit) begin
                        s_d.req      = 1'b1;
                        s_d.req_addr = s_q.addr;
                        s_d.req_data = s_d.word;
                        s_d.req_size = s_q.size;
                        s_d.addr     = s_q.addr + (ADDR_W'(1) << s_q.size);
                        s_d.cnt      = s_q.cnt - 1'b1;
                        s_d.bitc     = '0;
                        s_d.word     = '0;
                        if (s_q.cnt == CNT_W'(1)) s_d.st = ST_CRC;
                    end else begin
                        s_d.bitc = s_q.bitc + 1'b1;
                    end
                end
            end
            ST_CRC: begin
                if (sh_en) begin
                    s_d.rxcrc = rx_full;
                    if (s_q.bitc == BC_W'(CRC_W - 1)) begin
                        s_d.match = (~crc_q == rx_full);
                        s_d.bitc  = '0;
                        s_d.st    = ST_MATCH;
                    end else begin
                        s_d.bitc = s_q.bitc + 1'b1;
                    end
                end
            end
            ST_MATCH: begin
                if (sh_en) s_d.st = ST_CMD;
            end
            default: s_d.st = ST_CMD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tdo     = (s_q.st == ST_MATCH) && s_q.match;
    assign wr_req  = s_q.req;
    assign wr_addr = s_q.req_addr;
    assign wr_data = s_q.req_data;
    assign wr_size = s_q.req_size;

    // R5: a request lasts one cycle and carries a legal size code
    assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);
    assert_size_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_size != 2'd3));
    // R7: the data phase never runs with zero words left
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA) |-> (s_q.cnt != '0));
    // R4: waiting persists until a 1 bit is shifted
    assert_wait_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_WAIT) && !(sh_en && sh_bit)) |=> (s_q.st == ST_WAIT));
    // R9: the match bit is held until the next shift
    assert_match_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_MATCH) && !sh_en) |=> ((s_q.st == ST_MATCH) && $stable(tdo)));
endmodule

// File: tb/tb_burst_write_rx.sv
module tb_burst_write_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sh_en = 1'b0;
    logic        sh_bit = 1'b0;
    logic        bus_err = 1'b0;
    logic        tdo, wr_req, err_flag;
    logic [31:0] wr_addr, wr_data, err_addr;
    logic [1:0]  wr_size;

    burst_write_rx dut (
        .clk(clk), .rst_n(rst_n), .sh_en(sh_en), .sh_bit(sh_bit), .tdo(tdo),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size),
        .bus_err(bus_err), .err_flag(err_flag), .err_addr(err_addr)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int got_n = 0;
    logic [31:0] got_addr [64];
    logic [31:0] got_data [64];
    logic [1:0]  got_size [64];
    logic [31:0] last_addr;

    always @(negedge clk) begin
        if (rst_n && wr_req && got_n < 64) begin
            got_addr[got_n] = wr_addr;
            got_data[got_n] = wr_data;
            got_size[got_n] = wr_size;
            got_n = got_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_bit(input logic b);
        @(negedge clk);
        sh_en  = 1'b1;
        sh_bit = b;
    endtask

    task automatic idle_cyc();
        @(negedge clk);
        sh_en = 1'b0;
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
    endfunction

    task automatic send_cmd(input logic flag, input logic [3:0] op,
                            input logic [31:0] addr, input logic [15:0] cnt);
        logic [52:0] v;
        v = {flag, op, addr, cnt};
        for (int i = 52; i >= 0; i--) tick_bit(v[i]);
    endtask

    task automatic run_burst(input logic [3:0] op, input logic [31:0] addr,
                             input int cnt, input int zeros, input bit corrupt,
                             input bit gaps);
        logic [31:0] crc, tx, word, ea;
        logic [31:0] exp_data [64];
        int nbits, nb;
        logic t;
        got_n = 0;
        nb    = 1 << (op - 1);
        nbits = 8 * nb;
        crc   = 32'hFFFFFFFF;
        send_cmd(1'b0, op, addr, 16'(cnt));
        repeat (zeros) tick_bit(1'b0);
        tick_bit(1'b1);
        for (int w = 0; w < cnt; w++) begin
            word = $urandom;
            if (nbits < 32) word = word & ((32'h1 << nbits) - 1);
            exp_data[w] = word;
            for (int i = 0; i < nbits; i++) begin
                tick_bit(word[i]);
                crc = crc_step(crc, word[i]);
                if (gaps && ($urandom % 3 == 0)) idle_cyc();
            end
        end
        crc = ~crc;
        tx  = corrupt ? (crc ^ (32'h1 << ($urandom % 32))) : crc;
        for (int i = 0; i < 32; i++) tick_bit(tx[i]);
        @(negedge clk);
        t = tdo;
        sh_en = 1'b0;
        check(t == !corrupt, "R9 R8 match bit", 64'(t), 64'(!corrupt));
        idle_cyc();
        check(tdo == !corrupt, "R9 match bit held", 64'(tdo), 64'(!corrupt));
        tick_bit(1'b0);
        idle_cyc();
        idle_cyc();
        check(tdo == 1'b0, "R9 tdo low after return", 64'(tdo), 64'd0);
        check(got_n == cnt, "R7 request count", 64'(got_n), 64'(cnt));
        for (int w = 0; w < cnt && w < got_n; w++) begin
            ea = addr + 32'(w * nb);
            check(got_addr[w] == ea, "R6 request address", 64'(got_addr[w]), 64'(ea));
            check(got_data[w] == exp_data[w] && got_size[w] == 2'(op - 1),
                  "R5 request data and size",
                  {30'd0, got_size[w], got_data[w]},
                  {30'd0, 2'(op - 1), exp_data[w]});
            last_addr = ea;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        check({tdo, wr_req, err_flag, wr_size, wr_addr, wr_data, err_addr} == '0,
              "R1 outputs in reset", 64'(tdo), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({tdo, wr_req, err_flag, wr_size, wr_addr, wr_data, err_addr} == '0,
              "R1 outputs after reset", 64'(err_addr), 64'd0);

        // R2 R5 R6: directed bursts of each size
        run_burst(4'h3, 32'h1000_0000, 4, 0, 1'b0, 1'b0);
        run_burst(4'h1, 32'hFFFF_FFFE, 5, 3, 1'b0, 1'b1);
        run_burst(4'h2, 32'h0000_0100, 3, 1, 1'b0, 1'b0);
        // R7: zero count, good and bad CRC
        run_burst(4'h2, 32'h0000_2000, 0, 2, 1'b0, 1'b0);
        run_burst(4'h1, 32'h0000_2000, 0, 0, 1'b1, 1'b0);
        // R8: corrupted CRC with data
        run_burst(4'h3, 32'h0000_4000, 2, 0, 1'b1, 1'b0);

        // R10: capture, ignored command, clear on accept
        idle_cyc();
        @(negedge clk); bus_err = 1'b1;
        @(negedge clk); bus_err = 1'b0;
        @(negedge clk);
        check(err_flag == 1'b1, "R10 flag set", 64'(err_flag), 64'd1);
        check(err_addr == last_addr, "R10 address captured", 64'(err_addr), 64'(last_addr));

        // R3: ignored commands
        got_n = 0;
        send_cmd(1'b0, 4'h0, 32'h5, 16'd3);
        send_cmd(1'b1, 4'h3, 32'h5, 16'd3);
        send_cmd(1'b0, 4'h7, 32'h5, 16'd3);
        repeat (10) idle_cyc();
        check(got_n == 0, "R3 no requests from ignored commands", 64'(got_n), 64'd0);
        check(tdo == 1'b0, "R3 tdo low", 64'(tdo), 64'd0);
        check(err_flag == 1'b1, "R10 not cleared by ignored command", 64'(err_flag), 64'd1);
        run_burst(4'h3, 32'h0000_8000, 2, 0, 1'b0, 1'b0);
        check(err_flag == 1'b0 && err_addr == 32'h0, "R10 cleared on accept",
              64'(err_flag), 64'd0);

        // random bursts
        for (int k = 0; k < 12; k++) begin
            run_burst(4'(1 + $urandom % 3), $urandom, int'($urandom % 7),
                      int'($urandom % 6), ($urandom % 4) == 0, 1'b1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule